// File: doc/BRIEF.md
# Interrupt Source Controller with Edge and Level Sources

This block owns a fixed set of interrupt inputs. Each input is classified by parameter as either an edge-style message source or a level-style source, or it is left unclassified and inert. For every source the block keeps a destination server number, a priority, a spare saved priority and a small set of status flags. It turns input activity into presentation requests for a downstream presentation unit. It also reacts to three kinds of notice that come back from that unit: reject, end-of-interrupt and resend.

Masking has no separate enable bit. A priority of all ones (0xFF at the default width) masks a source. Message sources remember an event that arrived while masked, and they remember that their last presentation was refused. Level sources track whether they are currently presented, so they can be offered again while the line stays high.

Presentation requests leave through a registered valid/ready port, at most one per cycle. The lowest pending source index goes first. Each request carries the server, the global number (local index plus a base offset) and the priority. A resend notice starts a sequential walk over all sources, one source per cycle. The walk pauses while the output register holds an unaccepted request.

Top module: `irq_source_unit`

## Requirements
- R1: After reset no request is valid and every source is masked (priority all ones, status cleared). A message event on a masked source produces no request.
- R2: A request's global number equals the local index plus BASE. A notice whose number is outside [BASE, BASE+NSRC) has no effect.
- R3: A rising edge on an unmasked message source produces exactly one request carrying that source's server, global number and current priority.
- R4: A message event while masked sets masked-pending. A later configuration write with a priority other than all ones clears it and produces exactly one request. A second write produces nothing more.
- R5: A level source is presented when its line rises, it is unmasked and it is not already presented (sent); presenting sets sent. While sent is set, further line activity produces no request.
- R6: A reject on a message source marks it rejected. The next resend presents it once and clears the mark. If it is masked at resend time, the mark clears and nothing is presented.
- R7: A reject or end-of-interrupt on a level source clears sent without presenting; a following resend presents it again if the line is still high. An end-of-interrupt on a message source has no effect.
- R8: While pres_valid is high and pres_ready low, the request fields hold stable. Pending requests drain one per cycle in ascending index order when ready is held high.
- R9: An unclassified source (CLS_MASK bit 0) ignores its line: no request ever comes from it.
- R10: The resend walk does not advance while an unaccepted request occupies the output. Its requests appear after the held one is taken.
- R11: A level source whose line has fallen before a resend is not presented by that resend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_line | input | NSRC | Per-source interrupt lines (edge for message, level for level sources) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Local source index written |
| cfg_srv | input | SRV_W | New destination server |
| cfg_prio | input | PRIO_W | New priority (all ones masks) |
| cfg_saved | input | PRIO_W | New saved priority (stored only) |
| rej_vld | input | 1 | Reject notice strobe |
| rej_num | input | GNUM_W | Global number of the rejected source |
| eoi_vld | input | 1 | End-of-interrupt notice strobe |
| eoi_num | input | GNUM_W | Global number of the finished source |
| rsd_vld | input | 1 | Resend notice strobe (restarts the walk) |
| pres_valid | output | 1 | Request valid |
| pres_ready | input | 1 | Request accepted by the presentation unit |
| pres_srv | output | SRV_W | Destination server of the request |
| pres_num | output | GNUM_W | Global source number of the request |
| pres_prio | output | PRIO_W | Priority of the request |

## Verification
The assertions take for granted that the presentation side follows valid/ready rules and that notice strobes carry numbers the bench chooses deliberately, including out-of-range ones. They also assume reset starts from a defined state, so the output and scan pointer are known before the first checked edge. The stimulus changes inputs only on the falling clock edge, holds each notice for one cycle, and gives every action enough idle cycles to drain fully before the request log is judged. Ready is dropped only in the phases that test holding and scan stalling.

// File: rtl/isu_pkg.sv
package isu_pkg;
    // Per-source status flags
    typedef struct packed {
        logic asserted;   // level source: line currently high
        logic sent;       // level source: presented and not yet finished
        logic rejected;   // message source: last presentation refused
        logic mpend;      // message source: event arrived while masked
        logic req;        // request waiting for the output register
    } isu_flags_t;

    localparam isu_flags_t FLAGS_IDLE = '0;
endpackage

// File: rtl/isu_line_track.sv
module isu_line_track #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] line,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= line;
    end

    assign rise = line & ~prev_q;
endmodule

// File: rtl/isu_num_decode.sv
module isu_num_decode #(
    parameter int NSRC   = 8,
    parameter int GNUM_W = 12,
    parameter int BASE   = 256
) (
    input  logic              vld,
    input  logic [GNUM_W-1:0] num,
    output logic [NSRC-1:0]   hot
);
    logic [GNUM_W-1:0] off;
    logic              in_rng;

    always_comb begin
        off    = num - GNUM_W'(BASE);
        in_rng = (num >= GNUM_W'(BASE)) && (off < GNUM_W'(NSRC));
        hot    = (vld && in_rng) ? (NSRC'(1) << off) : '0;
    end
endmodule

// File: rtl/isu_pick.sv
module isu_pick #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req,
    output logic          hit,
    output logic [IW-1:0] idx
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_source_unit.sv
module irq_source_unit
    import isu_pkg::*;
#(
    parameter int              NSRC     = 8,
    parameter int              SRV_W    = 4,
    parameter int              PRIO_W   = 8,
    parameter int              GNUM_W   = 12,
    parameter int              BASE     = 256,
    parameter logic [NSRC-1:0] LSI_MASK = 8'b1111_0000,
    parameter logic [NSRC-1:0] CLS_MASK = 8'b0111_1111,
    localparam int             IDX_W    = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_line,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [SRV_W-1:0]  cfg_srv,
    input  logic [PRIO_W-1:0] cfg_prio,
    input  logic [PRIO_W-1:0] cfg_saved,
    input  logic              rej_vld,
    input  logic [GNUM_W-1:0] rej_num,
    input  logic              eoi_vld,
    input  logic [GNUM_W-1:0] eoi_num,
    input  logic              rsd_vld,
    output logic              pres_valid,
    input  logic              pres_ready,
    output logic [SRV_W-1:0]  pres_srv,
    output logic [GNUM_W-1:0] pres_num,
    output logic [PRIO_W-1:0] pres_prio
);
    localparam logic [PRIO_W-1:0] MASKED = '1;

    typedef struct packed {
        logic [NSRC-1:0][SRV_W-1:0]  srv;
        logic [NSRC-1:0][PRIO_W-1:0] prio;
        logic [NSRC-1:0][PRIO_W-1:0] saved;
        isu_flags_t [NSRC-1:0]       flg;
        logic                        scan_on;
        logic [IDX_W-1:0]            scan_ptr;
        logic                        out_vld;
        logic [SRV_W-1:0]            out_srv;
        logic [GNUM_W-1:0]           out_gnum;
        logic [PRIO_W-1:0]           out_prio;
    } st_t;

    st_t st_d, st_q;

    logic [NSRC-1:0]  rise;
    logic [NSRC-1:0]  rej_hot, eoi_hot;
    logic [NSRC-1:0]  req_vec;
    logic             pick_hit;
    logic [IDX_W-1:0] pick_idx;

    isu_line_track #(.N(NSRC)) u_lines (
        .clk(clk), .rst_n(rst_n), .line(src_line), .rise(rise)
    );

    isu_num_decode #(.NSRC(NSRC), .GNUM_W(GNUM_W), .BASE(BASE)) u_rej_dec (
        .vld(rej_vld), .num(rej_num), .hot(rej_hot)
    );

    isu_num_decode #(.NSRC(NSRC), .GNUM_W(GNUM_W), .BASE(BASE)) u_eoi_dec (
        .vld(eoi_vld), .num(eoi_num), .hot(eoi_hot)
    );

    always_comb begin
        for (int i = 0; i < NSRC; i++) req_vec[i] = st_q.flg[i].req;
    end

    isu_pick #(.N(NSRC), .IW(IDX_W)) u_pick (
        .req(req_vec), .hit(pick_hit), .idx(pick_idx)
    );

    logic slot_free, grant, scan_go;

    always_comb begin
        isu_flags_t       f;
        logic             chk;
        logic             lvl;
        logic             cls;
        logic             wr;
        logic [PRIO_W-1:0] pr;

        st_d      = st_q;
        slot_free = !st_q.out_vld || pres_ready;
        grant     = slot_free && pick_hit;
        scan_go   = st_q.scan_on && !st_q.out_vld;

        if (pres_ready) st_d.out_vld = 1'b0;

        // Output register load: a source masked after it queued is dropped
        if (grant && (st_q.prio[pick_idx] != MASKED)) begin
            st_d.out_vld  = 1'b1;
            st_d.out_srv  = st_q.srv[pick_idx];
            st_d.out_gnum = GNUM_W'(BASE) + GNUM_W'(pick_idx);
            st_d.out_prio = st_q.prio[pick_idx];
        end

        // Resend walk: one source per cycle, paused while output is held
        if (scan_go) begin
            if (st_q.scan_ptr == IDX_W'(NSRC - 1)) st_d.scan_on = 1'b0;
            else                                   st_d.scan_ptr = st_q.scan_ptr + 1'b1;
        end
        if (rsd_vld) begin
            st_d.scan_on  = 1'b1;
            st_d.scan_ptr = '0;
        end

        for (int i = 0; i < NSRC; i++) begin
            f   = st_q.flg[i];
            chk = 1'b0;
            lvl = LSI_MASK[i];
            cls = CLS_MASK[i];
            wr  = cfg_we && (cfg_idx == IDX_W'(i));

            if (grant && (pick_idx == IDX_W'(i))) begin
                f.req = 1'b0;
                if (st_q.prio[i] == MASKED) begin
                    if (lvl) f.sent  = 1'b0;
                    else     f.mpend = 1'b1;
                end
            end

            if (cls) begin
                if (rej_hot[i]) begin
                    if (lvl) f.sent     = 1'b0;
                    else     f.rejected = 1'b1;
                end
                if (eoi_hot[i] && lvl) f.sent = 1'b0;

                if (lvl) begin
                    f.asserted = src_line[i];
                    if (rise[i]) chk = 1'b1;
                end else if (rise[i]) begin
                    if (st_q.prio[i] == MASKED) f.mpend = 1'b1;
                    else                        f.req   = 1'b1;
                end

                if (scan_go && (st_q.scan_ptr == IDX_W'(i))) begin
                    if (lvl) begin
                        chk = 1'b1;
                    end else if (f.rejected) begin
                        f.rejected = 1'b0;
                        if (st_q.prio[i] != MASKED) f.req = 1'b1;
                    end
                end
            end

            if (wr) begin
                st_d.srv[i]   = cfg_srv;
                st_d.prio[i]  = cfg_prio;
                st_d.saved[i] = cfg_saved;
                if (cls) begin
                    if (lvl) begin
                        chk = 1'b1;
                    end else if (f.mpend && (cfg_prio != MASKED)) begin
                        f.mpend = 1'b0;
                        f.req   = 1'b1;
                    end
                end
            end

            pr = wr ? cfg_prio : st_q.prio[i];
            if (chk && lvl && (pr != MASKED) && f.asserted && !f.sent) begin
                f.sent = 1'b1;
                f.req  = 1'b1;
            end

            st_d.flg[i] = f;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.prio     <= {NSRC{MASKED}};
            st_q.saved    <= {NSRC{MASKED}};
        end else begin
            st_q <= st_d;
        end
    end

    assign pres_valid = st_q.out_vld;
    assign pres_srv   = st_q.out_srv;
    assign pres_num   = st_q.out_gnum;
    assign pres_prio  = st_q.out_prio;

    // R8: held request keeps its fields
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        pres_valid && !pres_ready |=> pres_valid && $stable(pres_srv)
                                      && $stable(pres_num) && $stable(pres_prio));

    // R1: a masked priority never reaches the output
    a_r1_no_masked_out: assert property (@(posedge clk) disable iff (!rst_n)
        pres_valid |-> pres_prio != MASKED);

    // R2: output number lies inside this unit's window
    a_r2_num_window: assert property (@(posedge clk) disable iff (!rst_n)
        pres_valid |-> (int'(pres_num) >= BASE) && (int'(pres_num) < BASE + NSRC));

    // R10: walk pointer frozen while the output is occupied
    a_r10_scan_stall: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.scan_on && st_q.out_vld && !rsd_vld |=> $stable(st_q.scan_ptr));

    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_src_chk
            if (!CLS_MASK[g]) begin : g_idle
                // R9: an unclassified source never queues a request
                a_r9_idle_src: assert property (@(posedge clk) disable iff (!rst_n)
                    !st_q.flg[g].req);
            end else if (LSI_MASK[g]) begin : g_lvl
                // R5: a level source queues only when it was marked sent
                a_r5_req_implies_sent: assert property (@(posedge clk) disable iff (!rst_n)
                    $rose(st_q.flg[g].req) |-> st_q.flg[g].sent);
            end else begin : g_msg
                // R4: masked-pending is raised only while masked
                a_r4_mpend_masked: assert property (@(posedge clk) disable iff (!rst_n)
                    $rose(st_q.flg[g].mpend) |-> (st_q.prio[g] == MASKED) || $past(st_q.prio[g] == MASKED));
            end
        end
    endgenerate
endmodule

// File: tb/sim_irq_source_unit.sv
module sim_irq_source_unit;
    localparam int NSRC = 8, SRV_W = 4, PRIO_W = 8, GNUM_W = 12, BASE = 256;
    localparam int IDX_W = 3;

    logic              clk = 0, rst_n = 0;
    logic [NSRC-1:0]   src_line = '0;
    logic              cfg_we = 0;
    logic [IDX_W-1:0]  cfg_idx = '0;
    logic [SRV_W-1:0]  cfg_srv = '0;
    logic [PRIO_W-1:0] cfg_prio = '0, cfg_saved = '0;
    logic              rej_vld = 0, eoi_vld = 0, rsd_vld = 0;
    logic [GNUM_W-1:0] rej_num = '0, eoi_num = '0;
    logic              pres_valid, pres_ready = 1;
    logic [SRV_W-1:0]  pres_srv;
    logic [GNUM_W-1:0] pres_num;
    logic [PRIO_W-1:0] pres_prio;

    irq_source_unit u0 (.*);

    always #2 clk = ~clk;   // 250 MHz

    int checks = 0, fails = 0, cyc = 0, log_n = 0;
    int lg_srv [0:63], lg_num [0:63], lg_prio [0:63], lg_cyc [0:63];
    int exp_srv [0:NSRC-1], exp_prio [0:NSRC-1];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && pres_valid && pres_ready && log_n < 64) begin
            lg_srv[log_n]  = int'(pres_srv);
            lg_num[log_n]  = int'(pres_num);
            lg_prio[log_n] = int'(pres_prio);
            lg_cyc[log_n]  = cyc;
            log_n++;
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(input int idx, input int srv, input int prio);
        cfg_we = 1; cfg_idx = IDX_W'(idx); cfg_srv = SRV_W'(srv);
        cfg_prio = PRIO_W'(prio); cfg_saved = PRIO_W'(prio);
        exp_srv[idx] = srv; exp_prio[idx] = prio;
        tick(1);
        cfg_we = 0;
    endtask

    task automatic pulse(input int idx);
        src_line[idx] = 1; tick(1); src_line[idx] = 0;
    endtask

    task automatic reject(input int num);
        rej_vld = 1; rej_num = GNUM_W'(num); tick(1); rej_vld = 0;
    endtask

    task automatic eoi(input int num);
        eoi_vld = 1; eoi_num = GNUM_W'(num); tick(1); eoi_vld = 0;
    endtask

    task automatic resend();
        rsd_vld = 1; tick(1); rsd_vld = 0;
    endtask

    task automatic expect_none(input string tag);
        chk(log_n == 0, tag, log_n, 0);
    endtask

    task automatic expect_entry(input int k, input string tag, input int idx);
        bit ok;
        ok = (log_n > k) && lg_num[k] == BASE + idx && lg_srv[k] == exp_srv[idx]
             && lg_prio[k] == exp_prio[idx];
        chk(ok, tag, (log_n > k) ? lg_num[k] * 65536 + lg_prio[k] * 16 + lg_srv[k] : -1,
            (BASE + idx) * 65536 + exp_prio[idx] * 16 + exp_srv[idx]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog all-reqs actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < NSRC; i++) begin exp_srv[i] = 0; exp_prio[i] = 255; end
        tick(3);
        rst_n = 1;
        tick(2);
        chk(pres_valid == 0, "R1 reset valid", int'(pres_valid), 0);

        // R1/R4: events on masked message sources, then unmask one at a time
        for (int i = 0; i < 4; i++) pulse(i);
        tick(4);
        expect_none("R1 masked pulses");
        for (int i = 0; i < 4; i++) begin
            log_n = 0;
            cfg(i, i + 1, i * 3 + 1);
            tick(4);
            chk(log_n == 1, "R4 count after unmask", log_n, 1);
            expect_entry(0, "R4 unmask present", i);
            log_n = 0;
            cfg(i, i + 1, i * 3 + 1);
            tick(4);
            expect_none("R4 second write silent");
        end

        // R3: sweep message sources and priorities
        for (int i = 0; i < 4; i++) begin
            for (int p = 0; p < 3; p++) begin
                log_n = 0;
                cfg(i, (i * 5 + 3) % 16, (p == 2) ? 254 : p * 37);
                pulse(i);
                tick(4);
                chk(log_n == 1, "R3 count", log_n, 1);
                expect_entry(0, "R3 present fields", i);
            end
        end

        // R5: level source 4
        log_n = 0;
        cfg(4, 9, 3);
        tick(3);
        expect_none("R5 low line no request");
        src_line[4] = 1; tick(4);
        chk(log_n == 1, "R5 rise count", log_n, 1);
        expect_entry(0, "R5 rise present", 4);
        log_n = 0;
        src_line[4] = 0; tick(2); src_line[4] = 1; tick(4);
        expect_none("R5 sent blocks re-present");

        // R2: out-of-window notices ignored (sent stays set, resend silent)
        reject(BASE + NSRC + 4);
        reject(BASE - 4);
        eoi(BASE + NSRC + 4);
        resend(); tick(15);
        expect_none("R2 out-of-window notices");

        // R7: EOI clears sent without presenting, resend re-presents
        eoi(BASE + 4); tick(4);
        expect_none("R7 eoi alone silent");
        resend(); tick(15);
        chk(log_n == 1, "R7 eoi+resend count", log_n, 1);
        expect_entry(0, "R7 eoi+resend", 4);
        log_n = 0;
        reject(BASE + 4); tick(3);
        expect_none("R7 reject alone silent");
        resend(); tick(15);
        expect_entry(0, "R7 reject+resend level", 4);

        // R11: line drops before resend
        log_n = 0;
        eoi(BASE + 4);
        src_line[4] = 0; tick(2);
        resend(); tick(15);
        expect_none("R11 dropped level not re-presented");

        // R6: message reject then resend
        reject(BASE + 1); tick(3);
        expect_none("R6 reject alone silent");
        resend(); tick(15);
        chk(log_n == 1, "R6 resend count", log_n, 1);
        expect_entry(0, "R6 resend present", 1);
        log_n = 0;
        resend(); tick(15);
        expect_none("R6 mark cleared");
        reject(BASE + 2);
        cfg(2, 2, 255);
        resend(); tick(15);
        expect_none("R6 masked at resend");
        cfg(2, 4, 254);
        tick(4);
        expect_none("R6 mark gone after mask");

        // R7: EOI on message source has no effect
        eoi(BASE + 3);
        resend(); tick(15);
        expect_none("R7 eoi on message source");

        // R8: hold and ordered drain
        pres_ready = 0;
        src_line[2:0] = 3'b111; tick(1); src_line[2:0] = 3'b000;
        tick(3);
        chk(pres_valid == 1 && int'(pres_num) == BASE, "R8 held head", int'(pres_num), BASE);
        tick(3);
        chk(pres_valid == 1 && int'(pres_num) == BASE && int'(pres_prio) == exp_prio[0],
            "R8 still held", int'(pres_prio), exp_prio[0]);
        pres_ready = 1;
        tick(6);
        chk(log_n == 3, "R8 drain count", log_n, 3);
        for (int k = 0; k < 3; k++) expect_entry(k, "R8 drain order", k);
        chk(lg_cyc[1] == lg_cyc[0] + 1 && lg_cyc[2] == lg_cyc[1] + 1,
            "R8 one per cycle", lg_cyc[2] - lg_cyc[0], 2);

        // R10: resend while output held
        log_n = 0;
        reject(BASE + 3);
        pres_ready = 0;
        pulse(0);
        resend();
        tick(20);
        chk(log_n == 0 && int'(pres_num) == BASE, "R10 held during walk", int'(pres_num), BASE);
        pres_ready = 1;
        tick(15);
        chk(log_n == 2, "R10 count", log_n, 2);
        expect_entry(0, "R10 held first", 0);
        expect_entry(1, "R10 walk result", 3);

        // R9: unclassified source 7
        log_n = 0;
        cfg(7, 5, 1);
        pulse(7); tick(2);
        src_line[7] = 1; tick(4); src_line[7] = 0;
        resend(); tick(15);
        expect_none("R9 unclassified silent");

        summary();
        $finish;
    end
endmodule